// File: doc/BRIEF.md
# SDRAM Mode-Set Command Generator

This block sits on a processor's internal write bus and turns stores into two reserved address windows into SDRAM mode-register-set commands. Each window belongs to one SDRAM area. The window at 0xFFFFD000 serves area 2 and the window at 0xFFFFE000 serves area 3. The data word of the store is thrown away. The mode value is the offset of the store address from its window base.

That offset is shifted right before it reaches the SDRAM address pins. The shift matches the way the memory's address lines are wired for the current bus width: by two for a 32-bit bus and by one for a 16-bit bus. The block then drives a single-cycle command on the chip select of the chosen area. It waits the mode-register delay and only then acknowledges the store, so the bus stays stalled until the memory can accept a new command.

A per-area copy of the last value sent is brought out for checking. A warm reset returns the sequencer to idle but keeps that copy and never re-sends a command.

Top module: `sdram_mode_writer`

## Requirements
- R1: A store whose address bits [31:12] equal 0xFFFFD selects area 2, which drives `sd_cs_n[0]` low. A store whose address bits [31:12] equal 0xFFFFE selects area 3, which drives `sd_cs_n[1]` low. At most one chip select is low at any time.
- R2: The value on `bus_wdata` has no effect on the command, the address driven or the stored copy.
- R3: With `cfg_wide`=1 (32-bit bus), `sd_addr` carries the offset shifted right by two. For example, a store to 0xFFFFD8C0 drives 0x230.
- R4: With `cfg_wide`=0 (16-bit bus), `sd_addr` carries the offset shifted right by one. For example, a store to 0xFFFFD8C0 drives 0x460. The width is sampled when the store is accepted.
- R5: A command holds the selected chip select, `sd_ras_n`, `sd_cas_n` and `sd_we_n` all low for exactly one clock, in the cycle after the accepting edge, with the mode value on `sd_addr`.
- R6: `bus_ack` rises for one clock after the command cycle plus TMRD further cycles, which is TMRD+2 clocks after the accepting edge. It stays low before that.
- R7: A store with an in-window offset above 0xFFC is acknowledged in the cycle after acceptance. It issues no command and leaves the stored copies unchanged.
- R8: A load from either window is acknowledged in the cycle after acceptance with `bus_rdata`=0 and issues no command.
- R9: Accesses outside both windows get no acknowledge and cause no command.
- R10: After `rst`, all chip selects and the three command strobes are high and `bus_ack` is low.
- R11: `warm_rst` returns the sequencer to idle, cancels any pending acknowledge, issues no command and keeps both stored copies. New stores work normally afterwards.
- R12: `shadow_a2` and `shadow_a3` each hold the last value sent to their own area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| warm_rst | input | 1 | Synchronous warm reset; keeps stored mode copies |
| cfg_wide | input | 1 | Bus width: 1 = 32-bit, 0 = 16-bit |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Access address |
| bus_wdata | input | 32 | Store data (ignored) |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 32 | Load data, always zero |
| sd_cs_n | output | 2 | Chip selects, bit 0 area 2, bit 1 area 3 |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write strobe |
| sd_addr | output | 12 | SDRAM address pins carrying the mode value |
| shadow_a2 | output | 12 | Last mode value sent to area 2 |
| shadow_a3 | output | 12 | Last mode value sent to area 3 |

## Verification
A store that issues a command shows it in the first cycle after the accepting edge and shows the acknowledge TMRD+2 cycles after that edge. Dropped stores and loads are acknowledged in the first cycle. The bench holds the request and counts falling edges from that point, recording the edge index at which the command and the acknowledge first appear and how many cycles the command lasts. It then compares those indices with the numbers above rather than waiting for any outcome. Cases that expect nothing count a fixed number of falling edges and require that neither a command nor an acknowledge appeared.

// File: rtl/sdmw_pkg.sv
package sdmw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_WAIT = 2'd2,
    ST_ACK  = 2'd3
  } seq_state_t;

  localparam int N_AREA = 2;
endpackage

// File: rtl/sdmw_decode.sv
module sdmw_decode #(
  parameter int             AW      = 32,
  parameter int             OFF_W   = 12,
  parameter logic [AW-1:0]  BASE_A2 = 32'hFFFF_D000,
  parameter logic [AW-1:0]  BASE_A3 = 32'hFFFF_E000,
  parameter logic [OFF_W-1:0] MAX_OFF = 12'hFFC
) (
  input  logic [AW-1:0]    addr,
  output logic             hit,
  output logic             area,
  output logic             in_range,
  output logic [OFF_W-1:0] off
);
  localparam int PAGE_W = AW - OFF_W;

  logic [PAGE_W-1:0] page;
  logic              hit_lo;
  logic              hit_hi;

  always_comb begin
    page     = addr[AW-1:OFF_W];
    off      = addr[OFF_W-1:0];
    hit_lo   = (page == BASE_A2[AW-1:OFF_W]);
    hit_hi   = (page == BASE_A3[AW-1:OFF_W]);
    hit      = hit_lo | hit_hi;
    area     = hit_hi;
    in_range = (off <= MAX_OFF);
  end

  always_comb begin
    p_one_window_r1: assert (!(hit_lo && hit_hi));
  end
endmodule

// File: rtl/sdmw_shift.sv
module sdmw_shift #(
  parameter int OFF_W = 12,
  parameter int SD_AW = 12
) (
  input  logic [OFF_W-1:0] off,
  input  logic             wide,
  output logic [SD_AW-1:0] mode_val
);
  logic [OFF_W-1:0] by_two;
  logic [OFF_W-1:0] by_one;

  always_comb begin
    by_two   = off >> 2;
    by_one   = off >> 1;
    mode_val = wide ? SD_AW'(by_two) : SD_AW'(by_one);
  end
endmodule

// File: rtl/sdmw_seq.sv
module sdmw_seq
  import sdmw_pkg::*;
#(
  parameter int SD_AW = 12,
  parameter int TMRD  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             warm_rst,
  input  logic             req,
  input  logic             we,
  input  logic             hit,
  input  logic             area,
  input  logic             in_range,
  input  logic [SD_AW-1:0] mode_val,
  output logic             ack,
  output logic [N_AREA-1:0] cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [SD_AW-1:0] sd_addr,
  output logic [SD_AW-1:0] shadow [N_AREA]
);
  localparam int CNT_W = (TMRD < 2) ? 1 : $clog2(TMRD + 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             issue;

  always_comb begin
    accept = (state == ST_IDLE) && req && hit;
    issue  = accept && we && in_range;
  end

  always_ff @(posedge clk) begin
    if (rst || warm_rst) begin
      state   <= ST_IDLE;
      cs_n    <= '1;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      we_n    <= 1'b1;
      ack     <= 1'b0;
      cnt     <= '0;
      sd_addr <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (issue) begin
            cs_n    <= ~(N_AREA'(1) << area);
            ras_n   <= 1'b0;
            cas_n   <= 1'b0;
            we_n    <= 1'b0;
            sd_addr <= mode_val;
            state   <= ST_CMD;
          end else if (accept) begin
            ack   <= 1'b1;
            state <= ST_ACK;
          end
        end
        ST_CMD: begin
          cs_n  <= '1;
          ras_n <= 1'b1;
          cas_n <= 1'b1;
          we_n  <= 1'b1;
          cnt   <= CNT_W'(TMRD - 1);
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            ack   <= 1'b1;
            state <= ST_ACK;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          ack   <= 1'b0;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  // Stored copies survive both resets; contents undefined until first command.
  always_ff @(posedge clk) begin
    if (issue && !rst && !warm_rst) shadow[area] <= mode_val;
  end

  p_single_cs_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n) <= 1);

  p_cmd_strobes_r5: assert property (@(posedge clk) disable iff (rst)
    (cs_n != '1) |-> (!ras_n && !cas_n && !we_n));

  p_cmd_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    !ras_n |=> (ras_n && cs_n == '1));

  p_no_ack_in_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    (cs_n != '1) |-> !ack);

  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  p_read_no_cmd_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && !we && !warm_rst) |=> (cs_n == '1 && ack));

  for (genvar g = 0; g < N_AREA; g++) begin : g_shadow_chk
    p_shadow_match_r12: assert property (@(posedge clk) disable iff (rst)
      !cs_n[g] |-> (shadow[g] == sd_addr));
  end
endmodule

// File: rtl/sdram_mode_writer.sv
module sdram_mode_writer
  import sdmw_pkg::*;
#(
  parameter int               AW      = 32,
  parameter int               DW      = 32,
  parameter int               OFF_W   = 12,
  parameter int               SD_AW   = 12,
  parameter int               TMRD    = 2,
  parameter logic [AW-1:0]    BASE_A2 = 32'hFFFF_D000,
  parameter logic [AW-1:0]    BASE_A3 = 32'hFFFF_E000,
  parameter logic [OFF_W-1:0] MAX_OFF = 12'hFFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              warm_rst,
  input  logic              cfg_wide,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic              bus_ack,
  output logic [DW-1:0]     bus_rdata,
  output logic [N_AREA-1:0] sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [SD_AW-1:0]  sd_addr,
  output logic [SD_AW-1:0]  shadow_a2,
  output logic [SD_AW-1:0]  shadow_a3
);
  logic             hit;
  logic             area;
  logic             in_range;
  logic [OFF_W-1:0] off;
  logic [SD_AW-1:0] mode_val;
  logic [SD_AW-1:0] shadow [N_AREA];
  logic             wdata_unused;

  assign wdata_unused = ^bus_wdata;
  assign bus_rdata    = '0;
  assign shadow_a2    = shadow[0];
  assign shadow_a3    = shadow[1];

  sdmw_decode #(
    .AW(AW), .OFF_W(OFF_W), .BASE_A2(BASE_A2), .BASE_A3(BASE_A3), .MAX_OFF(MAX_OFF)
  ) u_decode (
    .addr(bus_addr), .hit(hit), .area(area), .in_range(in_range), .off(off)
  );

  sdmw_shift #(.OFF_W(OFF_W), .SD_AW(SD_AW)) u_shift (
    .off(off), .wide(cfg_wide), .mode_val(mode_val)
  );

  sdmw_seq #(.SD_AW(SD_AW), .TMRD(TMRD)) u_seq (
    .clk(clk), .rst(rst), .warm_rst(warm_rst),
    .req(bus_req), .we(bus_we), .hit(hit), .area(area), .in_range(in_range),
    .mode_val(mode_val), .ack(bus_ack), .cs_n(sd_cs_n),
    .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
    .sd_addr(sd_addr), .shadow(shadow)
  );
endmodule

// File: tb/tb_sdram_mode_writer.sv
module tb_sdram_mode_writer;
  localparam int CLK_PERIOD = 10;
  localparam int TMRD       = 2;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        warm_rst = 1'b0;
  logic        cfg_wide = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic [1:0]  sd_cs_n;
  logic        sd_ras_n, sd_cas_n, sd_we_n;
  logic [11:0] sd_addr, shadow_a2, shadow_a3;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_mode_writer #(.TMRD(TMRD)) dut (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .cfg_wide(cfg_wide),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .shadow_a2(shadow_a2), .shadow_a3(shadow_a3)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        wide;
    logic [31:0] data;
    logic        cmd;
    logic [1:0]  cs;
    logic [11:0] val;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'hFFFF_D8C0, 1'b1, 32'hDEAD_BEEF, 1'b1, 2'b10, 12'h230},
    '{32'hFFFF_E8C0, 1'b1, 32'h0000_0000, 1'b1, 2'b01, 12'h230},
    '{32'hFFFF_D8C0, 1'b0, 32'h1111_2222, 1'b1, 2'b10, 12'h460},
    '{32'hFFFF_EFFC, 1'b1, 32'h5A5A_5A5A, 1'b1, 2'b01, 12'h3FF},
    '{32'hFFFF_D000, 1'b1, 32'hFFFF_FFFF, 1'b1, 2'b10, 12'h000},
    '{32'hFFFF_DFFC, 1'b0, 32'h0000_0001, 1'b1, 2'b10, 12'h7FE},
    '{32'hFFFF_DFFD, 1'b1, 32'h0000_0000, 1'b0, 2'b11, 12'h000},
    '{32'hFFFF_E123, 1'b0, 32'hCAFE_F00D, 1'b1, 2'b01, 12'h091}
  };

  logic [11:0] exp_a2, exp_a3;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Drives one access at a falling edge and watches up to max_cyc falling edges.
  task automatic access(input logic [31:0] a, input logic w, input logic [31:0] d,
                        input logic wd, input int max_cyc,
                        output int cmd_n, output int cmd_cnt, output logic [1:0] cs_seen,
                        output logic [11:0] addr_seen, output int ack_n, output logic [31:0] rd);
    bus_addr = a; bus_we = w; bus_wdata = d; cfg_wide = wd; bus_req = 1'b1;
    cmd_n = -1; cmd_cnt = 0; ack_n = -1; cs_seen = 2'b11; addr_seen = '0; rd = '1;
    for (int n = 1; n <= max_cyc; n++) begin
      @(negedge clk);
      if (sd_cs_n != 2'b11) begin
        if (cmd_n < 0) begin
          cmd_n = n; cs_seen = sd_cs_n; addr_seen = sd_addr;
        end
        cmd_cnt++;
      end
      if (bus_ack) begin
        ack_n = n; rd = bus_rdata;
        break;
      end
    end
    bus_req = 1'b0; bus_we = 1'b0;
    @(negedge clk);
    if (sd_cs_n != 2'b11) cmd_cnt++;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= WATCHDOG && !done) begin
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    int cn, cc, an;
    logic [1:0] cs;
    logic [11:0] av;
    logic [31:0] rd;

    repeat (3) @(negedge clk);
    // R10: reset state
    chk(sd_cs_n == 2'b11, "R10 cs_n", 32'(sd_cs_n), 32'h3);
    chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R10 strobes", 32'({sd_ras_n, sd_cas_n, sd_we_n}), 32'h7);
    chk(bus_ack == 1'b0, "R10 ack", 32'(bus_ack), 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // Vector table: R1, R3, R4, R5, R6, R7, R12
    for (int i = 0; i < NV; i++) begin
      access(VECS[i].addr, 1'b1, VECS[i].data, VECS[i].wide, 12, cn, cc, cs, av, an, rd);
      if (VECS[i].cmd) begin
        chk(cn == 1, "R5 cmd cycle", 32'(cn), 32'd1);
        chk(cc == 1, "R5 cmd length", 32'(cc), 32'd1);
        chk(cs == VECS[i].cs, "R1 chip select", 32'(cs), 32'(VECS[i].cs));
        chk(av == VECS[i].val, VECS[i].wide ? "R3 mode value" : "R4 mode value", 32'(av), 32'(VECS[i].val));
        chk(an == TMRD + 2, "R6 ack delay", 32'(an), 32'(TMRD + 2));
        if (VECS[i].cs == 2'b10) exp_a2 = VECS[i].val; else exp_a3 = VECS[i].val;
      end else begin
        chk(cc == 0, "R7 no command", 32'(cc), 32'd0);
        chk(an == 1, "R7 ack", 32'(an), 32'd1);
      end
      if (i >= 1) begin
        chk(shadow_a2 == exp_a2, "R12 area2 copy", 32'(shadow_a2), 32'(exp_a2));
        chk(shadow_a3 == exp_a3, "R12 area3 copy", 32'(shadow_a3), 32'(exp_a3));
      end
    end

    // R8: loads from both windows
    access(32'hFFFF_D8C0, 1'b0, 32'h0, 1'b1, 8, cn, cc, cs, av, an, rd);
    chk(an == 1, "R8 ack", 32'(an), 32'd1);
    chk(cc == 0, "R8 no command", 32'(cc), 32'd0);
    chk(rd == 32'h0, "R8 rdata", rd, 32'h0);
    access(32'hFFFF_E004, 1'b0, 32'h0, 1'b0, 8, cn, cc, cs, av, an, rd);
    chk(cc == 0 && an == 1, "R8 area3 load", 32'(cc), 32'd0);
    chk(shadow_a2 == exp_a2 && shadow_a3 == exp_a3, "R8 copies kept", 32'(shadow_a3), 32'(exp_a3));

    // R2: same address, different data
    access(32'hFFFF_D100, 1'b1, 32'h1234_5678, 1'b0, 12, cn, cc, cs, av, an, rd);
    chk(av == 12'h080, "R2 data A", 32'(av), 32'h080);
    access(32'hFFFF_D100, 1'b1, 32'h0000_0000, 1'b0, 12, cn, cc, cs, av, an, rd);
    chk(av == 12'h080 && shadow_a2 == 12'h080, "R2 data B", 32'(av), 32'h080);
    exp_a2 = 12'h080;

    // R9: outside both windows
    access(32'hFFFF_C8C0, 1'b1, 32'h0, 1'b1, 8, cn, cc, cs, av, an, rd);
    chk(an == -1 && cc == 0, "R9 below window", 32'(an), 32'hFFFF_FFFF);
    access(32'hFFFF_F000, 1'b1, 32'h0, 1'b1, 8, cn, cc, cs, av, an, rd);
    chk(an == -1 && cc == 0, "R9 above window", 32'(an), 32'hFFFF_FFFF);

    // R11: warm reset right after a command
    bus_addr = 32'hFFFF_E040; bus_we = 1'b1; cfg_wide = 1'b1; bus_req = 1'b1;
    @(negedge clk);
    chk(sd_cs_n == 2'b01 && sd_addr == 12'h010, "R11 command seen", 32'(sd_addr), 32'h010);
    exp_a3 = 12'h010;
    warm_rst = 1'b1; bus_req = 1'b0; bus_we = 1'b0;
    @(negedge clk);
    warm_rst = 1'b0;
    cc = 0; an = 0;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      if (sd_cs_n != 2'b11) cc++;
      if (bus_ack) an++;
    end
    chk(cc == 0, "R11 no reissue", 32'(cc), 32'd0);
    chk(an == 0, "R11 ack cancelled", 32'(an), 32'd0);
    chk(shadow_a3 == exp_a3 && shadow_a2 == exp_a2, "R11 copies kept", 32'(shadow_a2), 32'(exp_a2));
    access(32'hFFFF_E8C0, 1'b1, 32'h0, 1'b1, 12, cn, cc, cs, av, an, rd);
    chk(av == 12'h230 && an == TMRD + 2, "R11 works after warm reset", 32'(an), 32'(TMRD + 2));

    done = 1'b1;
    finish_run();
  end
endmodule